// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a small in-order processor core for a 32-bit load/store integer subset. It supports register-register add, subtract, AND, OR and set-less-than, a word load, a word store and a branch taken when two registers are equal. Every instruction moves through five stages, one clock per stage: fetch, decode with register read, execute with address calculation, memory access, and write-back. A pipeline register sits between each pair of stages and updates on every clock edge.

The core has a separate instruction memory and data memory, both held inside the block. A testbench fills them through two external write ports. The data memory also has a registered external read port, so the final memory contents can be inspected. The core does not detect hazards, forward results or stall. Programs must be padded with no-op words so that no instruction reads a register before the producing instruction has reached write-back.

Each instruction carries its own incremented program counter and its chosen destination register number along the pipeline. A branch is decided in the execute stage from that carried value. The program counter and the register-file write port are brought out so that execution can be traced.

Top module: `pipe5_core`

## Requirements
- R1: While `rst` is high, on every clock edge the program counter is cleared to 0 and all pipeline registers are cleared to a no-op, so `pc_o` reads 0 and `wb_en_o` reads 0.
- R2: Without a taken branch, `pc_o` grows by 4 on every clock. Instruction word k of a straight-line program is fetched in the k-th cycle after reset is released.
- R3: A register-type instruction uses opcode bits 31:26 = 0x00, reads its sources from bits 25:21 and 20:16, and writes the register named in bits 15:11. The function field in bits 5:0 selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than giving 1 or 0.
- R4: A load (opcode 0x23) reads the data word at address (register[25:21] + sign-extended bits 15:0). It writes that word to the register named in bits 20:16, even when bits 15:11 hold another value.
- R5: A store (opcode 0x2B) writes register[20:16] into the data word at address (register[25:21] + sign-extended bits 15:0). It never raises `wb_en_o`. A later load of that address returns the stored value.
- R6: A branch (opcode 0x04) fetched in cycle c compares register[25:21] with register[20:16] in execute. If they are equal, `pc_o` in cycle c+3 is (its own address + 4) + (sign-extended bits 15:0 shifted left by 2), and the two words after the branch still execute. If they are not equal, fetch continues in sequence.
- R7: Register 0 always reads as zero. A write aimed at register 0 has no effect and does not raise `wb_en_o`.
- R8: An instruction in decode that reads a register being written back in the same cycle receives the new value.
- R9: The write-back of an instruction fetched in cycle c appears on `wb_en_o`/`wb_reg_o`/`wb_data_o` in cycle c+4. It uses the destination number carried with that instruction.
- R10: The all-zero word and any word whose opcode or function code is not listed above act as no-ops. They write no register and no memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_we | input | 1 | Write strobe for instruction memory preload |
| imem_waddr | input | IAW (6) | Word index for instruction preload |
| imem_wdata | input | 32 | Instruction word to preload |
| dmem_we_ext | input | 1 | Write strobe for data memory preload |
| dmem_addr_ext | input | DAW (6) | Word index for external data write and read |
| dmem_wdata_ext | input | 32 | Data word to preload |
| dmem_rdata_ext | output | 32 | Registered external read of the data word at `dmem_addr_ext` |
| pc_o | output | 32 | Current fetch address |
| wb_en_o | output | 1 | A register write takes place this cycle |
| wb_reg_o | output | 5 | Register number being written |
| wb_data_o | output | 32 | Value being written |

## Verification
Write-back of one instruction and the register read of a younger instruction in decode can fall in the same cycle. The program provokes this by placing a consumer exactly three words after its producer. In one case the producer is a load and the consumer an add. In another the producer aims at register 0 and the consumer reads register 0. The consumer's own write-back value then shows whether the new value was passed through for a real register and withheld for register 0. Every write-back event is also matched against a table by its cycle, register number and value, and that table is derived by hand from the program.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam int XLEN   = 32;
  localparam int NREGS  = 32;
  localparam int REG_AW = $clog2(NREGS);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    dst_is_rd;
    logic    use_imm;
    logic    branch;
    logic    mem_read;
    logic    mem_write;
    logic    load_to_reg;
    alu_op_e alu_op;
  } ctrl_t;

  typedef struct packed {
    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] instr;
  } ifid_t;

  typedef struct packed {
    ctrl_t             ctrl;
    logic [XLEN-1:0]   pc4;
    logic [XLEN-1:0]   src_a;
    logic [XLEN-1:0]   src_b;
    logic [XLEN-1:0]   imm;
    logic [REG_AW-1:0] dst;
  } idex_t;

  typedef struct packed {
    logic              reg_write;
    logic              mem_read;
    logic              mem_write;
    logic              load_to_reg;
    logic [REG_AW-1:0] dst;
    logic [XLEN-1:0]   alu_res;
    logic [XLEN-1:0]   st_val;
  } exmem_t;

  typedef struct packed {
    logic              reg_write;
    logic              load_to_reg;
    logic [REG_AW-1:0] dst;
    logic [XLEN-1:0]   alu_res;
    logic [XLEN-1:0]   ld_val;
  } memwb_t;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_write = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.reg_write = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.reg_write   = 1'b1;
        ctrl.use_imm     = 1'b1;
        ctrl.mem_read    = 1'b1;
        ctrl.load_to_reg = 1'b1;
      end
      OP_STORE: begin
        ctrl.use_imm   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      default: ctrl = '0;
    endcase
  end

  // R10
  always_comb begin
    if (opcode != OP_RTYPE && opcode != OP_LOAD &&
        opcode != OP_STORE && opcode != OP_BEQ) begin
      unknown_op_quiet_chk: assert (!ctrl.reg_write && !ctrl.mem_write && !ctrl.branch);
    end
  end

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter  int NREGS = 32,
  parameter  int W     = 32,
  parameter  int NRD   = 2,
  localparam int AW    = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr [NRD],
  output logic [W-1:0]  rdata [NRD]
);

  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (raddr[p] == '0) begin
        rdata[p] = '0;
      end else if (we && waddr == raddr[p]) begin
        rdata[p] = wdata;
      end else begin
        rdata[p] = regs[raddr[p]];
      end
    end

    // R7
    always @(posedge clk) begin
      if (raddr[p] == '0) begin
        zero_reg_chk: assert (rdata[p] == '0);
      end
    end
  end

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
  import pipe5_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  logic [W-1:0] diff;
  logic         lt;

  assign diff = a - b;
  assign lt   = $signed(a) < $signed(b);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = diff;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, lt};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IAW        = $clog2(IMEM_WORDS),
  localparam int DAW        = $clog2(DMEM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imem_we,
  input  logic [IAW-1:0]  imem_waddr,
  input  logic [31:0]     imem_wdata,
  input  logic            dmem_we_ext,
  input  logic [DAW-1:0]  dmem_addr_ext,
  input  logic [31:0]     dmem_wdata_ext,
  output logic [31:0]     dmem_rdata_ext,
  output logic [31:0]     pc_o,
  output logic            wb_en_o,
  output logic [4:0]      wb_reg_o,
  output logic [31:0]     wb_data_o
);

  // ---------------- memories ----------------
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  always_ff @(posedge clk) begin
    if (imem_we) begin
      imem[imem_waddr] <= imem_wdata;
    end
  end

  // ---------------- pipeline state ----------------
  logic [XLEN-1:0] pc_q;
  ifid_t           ifid_q;
  idex_t           idex_q;
  exmem_t          exmem_q;
  memwb_t          memwb_q;

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc4_f;
  logic [XLEN-1:0] instr_f;
  logic [XLEN-1:0] br_target;
  logic            take_br;
  logic [XLEN-1:0] pc_next;

  assign pc4_f   = pc_q + 32'd4;
  assign instr_f = imem[pc_q[IAW+1:2]];
  assign pc_next = take_br ? br_target : pc4_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      ifid_q <= '0;
    end else begin
      pc_q         <= pc_next;
      ifid_q.pc4   <= pc4_f;
      ifid_q.instr <= instr_f;
    end
  end

  // ---------------- decode ----------------
  logic [5:0]        opcode_d;
  logic [5:0]        funct_d;
  logic [REG_AW-1:0] rs_d;
  logic [REG_AW-1:0] rt_d;
  logic [REG_AW-1:0] rd_d;
  logic [XLEN-1:0]   imm_d;
  ctrl_t             ctrl_d;
  logic [REG_AW-1:0] rf_raddr [2];
  logic [XLEN-1:0]   rf_rdata [2];
  logic              rf_we;
  logic [XLEN-1:0]   wb_data;

  assign opcode_d = ifid_q.instr[31:26];
  assign rs_d     = ifid_q.instr[25:21];
  assign rt_d     = ifid_q.instr[20:16];
  assign rd_d     = ifid_q.instr[15:11];
  assign funct_d  = ifid_q.instr[5:0];
  assign imm_d    = {{(XLEN-16){ifid_q.instr[15]}}, ifid_q.instr[15:0]};

  assign rf_raddr[0] = rs_d;
  assign rf_raddr[1] = rt_d;

  pipe5_decode i_decode (
    .opcode (opcode_d),
    .funct  (funct_d),
    .ctrl   (ctrl_d)
  );

  pipe5_regfile #(
    .NREGS (NREGS),
    .W     (XLEN),
    .NRD   (2)
  ) i_regfile (
    .clk   (clk),
    .we    (rf_we),
    .waddr (memwb_q.dst),
    .wdata (wb_data),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idex_q <= '0;
    end else begin
      idex_q.ctrl  <= ctrl_d;
      idex_q.pc4   <= ifid_q.pc4;
      idex_q.src_a <= rf_rdata[0];
      idex_q.src_b <= rf_rdata[1];
      idex_q.imm   <= imm_d;
      idex_q.dst   <= ctrl_d.dst_is_rd ? rd_d : rt_d;
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_y;
  logic            alu_zero;

  assign alu_b = idex_q.ctrl.use_imm ? idex_q.imm : idex_q.src_b;

  pipe5_alu #(.W(XLEN)) i_alu (
    .a    (idex_q.src_a),
    .b    (alu_b),
    .op   (idex_q.ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  assign br_target = idex_q.pc4 + {idex_q.imm[XLEN-3:0], 2'b00};
  assign take_br   = idex_q.ctrl.branch & alu_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      exmem_q <= '0;
    end else begin
      exmem_q.reg_write   <= idex_q.ctrl.reg_write;
      exmem_q.mem_read    <= idex_q.ctrl.mem_read;
      exmem_q.mem_write   <= idex_q.ctrl.mem_write;
      exmem_q.load_to_reg <= idex_q.ctrl.load_to_reg;
      exmem_q.dst         <= idex_q.dst;
      exmem_q.alu_res     <= alu_y;
      exmem_q.st_val      <= idex_q.src_b;
    end
  end

  // ---------------- memory ----------------
  logic [DAW-1:0]  dm_idx;
  logic [XLEN-1:0] ld_val;

  assign dm_idx = exmem_q.alu_res[DAW+1:2];
  assign ld_val = exmem_q.mem_read ? dmem[dm_idx] : '0;

  always_ff @(posedge clk) begin
    if (exmem_q.mem_write) begin
      dmem[dm_idx] <= exmem_q.st_val;
    end else if (dmem_we_ext) begin
      dmem[dmem_addr_ext] <= dmem_wdata_ext;
    end
    dmem_rdata_ext <= dmem[dmem_addr_ext];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      memwb_q <= '0;
    end else begin
      memwb_q.reg_write   <= exmem_q.reg_write;
      memwb_q.load_to_reg <= exmem_q.load_to_reg;
      memwb_q.dst         <= exmem_q.dst;
      memwb_q.alu_res     <= exmem_q.alu_res;
      memwb_q.ld_val      <= ld_val;
    end
  end

  // ---------------- write-back ----------------
  assign wb_data = memwb_q.load_to_reg ? memwb_q.ld_val : memwb_q.alu_res;
  assign rf_we   = memwb_q.reg_write;

  assign pc_o      = pc_q;
  assign wb_en_o   = memwb_q.reg_write && (memwb_q.dst != '0);
  assign wb_reg_o  = memwb_q.dst;
  assign wb_data_o = wb_data;

  logic unused_ok;
  assign unused_ok = ^{pc_q[1:0], pc_q[XLEN-1:IAW+2], exmem_q.alu_res[1:0],
                       exmem_q.alu_res[XLEN-1:DAW+2], idex_q.ctrl.dst_is_rd,
                       ifid_q.instr[10:6], idex_q.imm[XLEN-1:XLEN-2]};

  // ---------------- assertions ----------------
  // R1
  pc_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc_q == '0 && !wb_en_o));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(take_br)) |-> (pc_q == $past(pc_q) + 32'd4));

  // R6
  br_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(take_br)) |-> (pc_q == $past(idex_q.pc4) + {$past(idex_q.imm[XLEN-3:0]), 2'b00}));

  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    exmem_q.mem_write |=> !wb_en_o);

endmodule

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;

  localparam int IW = 6;
  localparam int DW = 6;
  localparam int NEV = 14;
  localparam int RUN = 41;

  // one row per expected write-back: {cycle, register, value}
  localparam logic [47:0] TRACE [NEV] = '{
    {8'd4,  8'd1,  32'd100},
    {8'd5,  8'd2,  32'hFFFF_FFF9},
    {8'd6,  8'd3,  32'h0000_0F0F},
    {8'd8,  8'd4,  32'd93},
    {8'd9,  8'd5,  32'd107},
    {8'd10, 8'd6,  32'h0000_0004},
    {8'd11, 8'd7,  32'hFFFF_FFFF},
    {8'd12, 8'd8,  32'd1},
    {8'd13, 8'd9,  32'd0},
    {8'd17, 8'd10, 32'd100},
    {8'd19, 8'd11, 32'd200},
    {8'd22, 8'd12, 32'd93},
    {8'd23, 8'd13, 32'd111},
    {8'd24, 8'd14, 32'h0000_A5A5}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            imem_we = 1'b0;
  logic [IW-1:0]   imem_waddr = '0;
  logic [31:0]     imem_wdata = '0;
  logic            dmem_we_ext = 1'b0;
  logic [DW-1:0]   dmem_addr_ext = '0;
  logic [31:0]     dmem_wdata_ext = '0;
  logic [31:0]     dmem_rdata_ext;
  logic [31:0]     pc_o;
  logic            wb_en_o;
  logic [4:0]      wb_reg_o;
  logic [31:0]     wb_data_o;

  int total = 0;
  int bad   = 0;
  logic [31:0] prog [64];
  logic [47:0] seen [32];
  int nseen = 0;

  always #10 clk = ~clk;

  pipe5_core i_pipe5_core (
    .clk            (clk),
    .rst            (rst),
    .imem_we        (imem_we),
    .imem_waddr     (imem_waddr),
    .imem_wdata     (imem_wdata),
    .dmem_we_ext    (dmem_we_ext),
    .dmem_addr_ext  (dmem_addr_ext),
    .dmem_wdata_ext (dmem_wdata_ext),
    .dmem_rdata_ext (dmem_rdata_ext),
    .pc_o           (pc_o),
    .wb_en_o        (wb_en_o),
    .wb_reg_o       (wb_reg_o),
    .wb_data_o      (wb_data_o)
  );

  function automatic logic [31:0] enc_r(input int rd, input int rs, input int rt, input logic [5:0] fn);
    logic [4:0] a = rs[4:0];
    logic [4:0] b = rt[4:0];
    logic [4:0] d = rd[4:0];
    return {6'h00, a, b, d, 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    logic [4:0]  a = rs[4:0];
    logic [4:0]  b = rt[4:0];
    logic [15:0] k = imm[15:0];
    return {op, a, b, k};
  endfunction

  function automatic string tag_of(input int idx);
    case (idx)
      0, 1, 2, 13: return "R4 load";
      3:           return "R8 same-cycle read";
      9:           return "R7 zero register";
      10:          return "R6 slot after branch";
      11:          return "R5 load of stored word";
      default:     return "R3 register op";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build_program();
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[0]  = enc_i(6'h23, 0, 1, 0);          // load r1
    prog[1]  = enc_i(6'h23, 0, 2, 4);          // load r2
    prog[2]  = enc_i(6'h23, 0, 3, 8);          // load r3
    prog[3]  = 32'h0;
    prog[4]  = enc_r(4, 1, 2, 6'h20);          // add, r2 arrives same cycle
    prog[5]  = enc_r(5, 1, 2, 6'h22);          // sub
    prog[6]  = enc_r(6, 3, 1, 6'h24);          // and
    prog[7]  = enc_r(7, 3, 2, 6'h25);          // or
    prog[8]  = enc_r(8, 2, 1, 6'h2A);          // slt true
    prog[9]  = enc_r(9, 1, 2, 6'h2A);          // slt false
    prog[10] = enc_r(0, 1, 1, 6'h20);          // write aimed at r0
    prog[11] = enc_i(6'h2B, 0, 4, 12);         // store r4 to word 3
    prog[12] = 32'h0;
    prog[13] = enc_r(10, 0, 1, 6'h20);         // reads r0 as r0 is "written"
    prog[14] = enc_i(6'h04, 1, 1, 3);          // taken branch to word 18
    prog[15] = enc_r(11, 1, 1, 6'h20);         // slot, executes
    prog[16] = 32'h0;
    prog[17] = enc_r(15, 1, 1, 6'h20);         // skipped
    prog[18] = enc_i(6'h04, 1, 2, 5);          // not taken
    prog[19] = enc_i(6'h23, 0, 12, 12);        // load stored word
    prog[20] = enc_r(13, 5, 6, 6'h20);
    prog[21] = enc_i(6'h23, 10, 14, -4);       // negative offset, bits 15:11 = 31
    prog[22] = enc_i(6'h04, 0, 0, -1);         // backward loop onto itself
  endtask

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    build_program();
    repeat (2) @(negedge clk);
    // R1: state while reset is held
    check("R1 pc in reset", pc_o, 32'h0);
    check("R1 wb_en in reset", {31'd0, wb_en_o}, 32'h0);

    for (int i = 0; i < 64; i++) begin
      imem_we    = 1'b1;
      imem_waddr = i[IW-1:0];
      imem_wdata = prog[i];
      @(negedge clk);
    end
    imem_we = 1'b0;

    dmem_we_ext = 1'b1;
    dmem_addr_ext = 6'd0;  dmem_wdata_ext = 32'd100;       @(negedge clk);
    dmem_addr_ext = 6'd1;  dmem_wdata_ext = 32'hFFFF_FFF9; @(negedge clk);
    dmem_addr_ext = 6'd2;  dmem_wdata_ext = 32'h0000_0F0F; @(negedge clk);
    dmem_addr_ext = 6'd3;  dmem_wdata_ext = 32'h0;         @(negedge clk);
    dmem_addr_ext = 6'd24; dmem_wdata_ext = 32'h0000_A5A5; @(negedge clk);
    dmem_we_ext = 1'b0;
    dmem_addr_ext = 6'd3;

    rst = 1'b0;
    for (int n = 0; n < RUN; n++) begin
      if (wb_en_o && nseen < 32) begin
        seen[nseen] = {n[7:0], 3'b000, wb_reg_o, wb_data_o};
        nseen++;
      end
      if (n == 0)  check("R2 pc first cycle", pc_o, 32'd0);
      if (n == 10) check("R2 pc sequential", pc_o, 32'd40);
      if (n == 17) check("R6 taken forward target", pc_o, 32'd72);
      if (n == 20) check("R6 not taken continues", pc_o, 32'd84);
      if (n == 24) check("R6 taken backward target", pc_o, 32'd88);
      @(negedge clk);
    end

    // R9 R10: exact number of write-backs (no-ops and skipped word add none)
    check("R9 R10 write-back count", nseen, NEV);
    for (int k = 0; k < NEV; k++) begin
      logic [47:0] got;
      got = (k < nseen) ? seen[k] : 48'hFFFF_FFFF_FFFF;
      check({"R9 cycle, ", tag_of(k)}, {24'd0, got[47:40]}, {24'd0, TRACE[k][47:40]});
      check({"R9 dest, ", tag_of(k)}, {24'd0, got[39:32]}, {24'd0, TRACE[k][39:32]});
      check(tag_of(k), got[31:0], TRACE[k][31:0]);
    end

    // R5: stored word visible at the external read port
    @(negedge clk);
    check("R5 stored word 3", dmem_rdata_ext, 32'd93);
    dmem_addr_ext = 6'd0;
    @(negedge clk);
    check("R5 word 0 untouched", dmem_rdata_ext, 32'd100);

    // R1: reset applied in the middle of a run
    rst = 1'b1;
    @(negedge clk);
    check("R1 pc after mid-run reset", pc_o, 32'h0);
    check("R1 wb_en after mid-run reset", {31'd0, wb_en_o}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule